// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts a single 128-bit block under a 128-bit key with the AES-128 cipher. The datapath holds one state register. It evaluates one complete round per clock: all sixteen state bytes go through the substitution function in parallel, then the row rotation, the column mixing (omitted in the last round) and the round-key XOR. The next round key is expanded from the current one in the same cycle, so only the current round key is ever held.

A host places the plaintext and key on the inputs and raises `start` for one cycle while `busy` is low. The core first XORs the plaintext with the key. It then runs ten rounds, drops `busy` and pulses `done` for one cycle with the ciphertext on `cipherText`. The ciphertext stays there until the next accepted start.

Top module: `aes128IterCore`

## Requirements
- R1: Once a synchronous reset is released, `busy` and `done` are low and `cipherText` is all zeros.
- R2: A `start` sampled high while `busy` is low is accepted, and `busy` is high in the following cycle.
- R3: `done` rises on the 11th rising edge counting the accepting edge as the first. `busy` is high for exactly 10 cycles before that, and `done` is never high together with `busy`.
- R4: `done` lasts exactly one cycle per accepted start.
- R5: A `start` raised while `busy` is high is ignored. The running block finishes at its original time with the ciphertext of its original inputs.
- R6: Key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff yields ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a.
- R7: While `busy` is low and no start is accepted, `cipherText` does not change.
- R8: Byte k of any 128-bit port occupies bits [127-8k:120-8k]. The state holds byte k at row k mod 4, column k div 4.
- R9: For arbitrary keys and plaintexts, the output equals AES-128: an initial key XOR, nine full rounds, and a final round without column mixing (matrix {02,03,01,01} circulant, polynomial 0x11B). Each round uses the key expanded with round constants 01,02,04,...,1b,36.
- R10: A start raised in the same cycle as `done` is accepted, and that block completes with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an encryption when idle |
| plainText | input | 128 | Plaintext block, sampled at an accepted start |
| cipherKey | input | 128 | Cipher key, sampled at an accepted start |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle pulse when the result is ready |
| cipherText | output | 128 | Result of the last completed encryption |

## Verification
The published key-and-plaintext pair exercises the byte mapping end to end and fixes the absolute answer. Several random key and plaintext pairs are compared against an independent byte-array model. That model derives its substitution table by brute-force inversion, so any error in the round-constant sequence, the last-round handling or the row-rotation direction shows up as a mismatch. Restarting during a run shows whether the inputs are re-sampled. A start placed exactly on `done` separates correct idle detection from an off-by-one in the busy window.

// File: rtl/aesCorePkg.sv
package aesCorePkg;

  typedef struct packed {
    logic load;  // capture inputs, apply initial key XOR
    logic step;  // perform one round
    logic last;  // current round omits column mixing
  } aesCtrlT;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // Inverse as a^254 (product of a^2 .. a^128), then affine map.
  function automatic logic [7:0] subByte(input logic [7:0] a);
    logic [7:0] pw;
    logic [7:0] inv;
    pw = a;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw = gfMul(pw, pw);
      inv = gfMul(inv, pw);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aesRoundPath.sv
module aesRoundPath
  import aesCorePkg::*;
#(
  parameter int BYTES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  aesCtrlT              ctrl,
  input  logic [8*BYTES-1:0]   plainText,
  input  logic [8*BYTES-1:0]   cipherKey,
  output logic [8*BYTES-1:0]   stateOut
);
  localparam int W = 8 * BYTES;
  localparam int COLS = BYTES / 4;

  logic [W-1:0] stateReg, keyReg, subVal, shiftVal, mixVal, nextKey;
  logic [7:0]   rcon;
  logic [31:0]  rotWord, subWord, tmpWord;

  // byte k sits at bits [W-1-8k -: 8]; row k%4, column k/4
  for (genvar k = 0; k < BYTES; k++) begin : gSub
    assign subVal[W-1-8*k -: 8] = subByte(stateReg[W-1-8*k -: 8]);
  end

  for (genvar k = 0; k < BYTES; k++) begin : gShift
    localparam int ROW = k % 4;
    localparam int COL = k / 4;
    localparam int SRC = ROW + 4 * ((COL + ROW) % COLS);
    assign shiftVal[W-1-8*k -: 8] = subVal[W-1-8*SRC -: 8];
  end

  for (genvar c = 0; c < COLS; c++) begin : gMix
    logic [7:0] b0, b1, b2, b3;
    assign b0 = shiftVal[W-1-32*c    -: 8];
    assign b1 = shiftVal[W-1-32*c-8  -: 8];
    assign b2 = shiftVal[W-1-32*c-16 -: 8];
    assign b3 = shiftVal[W-1-32*c-24 -: 8];
    assign mixVal[W-1-32*c -: 32] = {
      xtime(b0) ^ gfMul(b1, 8'h03) ^ b2 ^ b3,
      b0 ^ xtime(b1) ^ gfMul(b2, 8'h03) ^ b3,
      b0 ^ b1 ^ xtime(b2) ^ gfMul(b3, 8'h03),
      gfMul(b0, 8'h03) ^ b1 ^ b2 ^ xtime(b3)
    };
  end

  // on-the-fly key expansion, in step with the round
  assign rotWord = {keyReg[23:0], keyReg[31:24]};
  for (genvar j = 0; j < 4; j++) begin : gKeySub
    assign subWord[31-8*j -: 8] = subByte(rotWord[31-8*j -: 8]);
  end
  assign tmpWord = subWord ^ {rcon, 24'h000000};

  for (genvar c = 0; c < COLS; c++) begin : gKeyWord
    if (c == 0) begin : gFirst
      assign nextKey[W-1 -: 32] = keyReg[W-1 -: 32] ^ tmpWord;
    end else begin : gRest
      assign nextKey[W-1-32*c -: 32] = keyReg[W-1-32*c -: 32] ^ nextKey[W-1-32*(c-1) -: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateReg <= '0;
      keyReg   <= '0;
      rcon     <= 8'h01;
    end else if (ctrl.load) begin
      stateReg <= plainText ^ cipherKey;
      keyReg   <= cipherKey;
      rcon     <= 8'h01;
    end else if (ctrl.step) begin
      stateReg <= (ctrl.last ? shiftVal : mixVal) ^ nextKey;
      keyReg   <= nextKey;
      rcon     <= xtime(rcon);
    end
  end

  assign stateOut = stateReg;
endmodule

// File: rtl/aesSeqCtrl.sv
module aesSeqCtrl
  import aesCorePkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output aesCtrlT ctrl,
  output logic    busy,
  output logic    done
);
  localparam int CW = $clog2(ROUNDS + 1);

  logic [CW-1:0] roundIdx;

  assign ctrl.load = start && !busy;
  assign ctrl.step = busy;
  assign ctrl.last = busy && (roundIdx == CW'(ROUNDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      roundIdx <= CW'(1);
    end else begin
      done <= 1'b0;
      if (ctrl.load) begin
        busy     <= 1'b1;
        roundIdx <= CW'(1);
      end else if (busy) begin
        if (ctrl.last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          roundIdx <= roundIdx + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/aes128IterCore.sv
module aes128IterCore
  import aesCorePkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [127:0] plainText,
  input  logic [127:0] cipherKey,
  output logic         busy,
  output logic         done,
  output logic [127:0] cipherText
);
  aesCtrlT ctrl;

  aesSeqCtrl #(.ROUNDS(ROUNDS)) uCtrl (
    .clk(clk), .rst(rst), .start(start), .ctrl(ctrl), .busy(busy), .done(done)
  );

  aesRoundPath #(.BYTES(16)) uPath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .plainText(plainText),
    .cipherKey(cipherKey), .stateOut(cipherText)
  );
endmodule

// File: rtl/aesCoreChecker.sv
module aesCoreChecker #(
  parameter int ROUNDS = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:0] cipherText
);
  localparam int CW = $clog2(ROUNDS + 2);
  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (rst) busyCnt <= '0;
    else if (start && !busy) busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + CW'(1);
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);                              // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                         // R3
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    done |-> (busyCnt == CW'(ROUNDS)));                      // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                         // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(cipherText));              // R7
endmodule

bind aes128IterCore aesCoreChecker #(.ROUNDS(ROUNDS)) uChecker (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .cipherText(cipherText)
);

// File: tb/aes128IterCore_test.sv
module aes128IterCore_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] plainText = '0;
  logic [127:0] cipherKey = '0;
  logic         busy, done;
  logic [127:0] cipherText;

  int checks = 0;
  int fails = 0;
  logic [7:0] sbTbl [256];

  aes128IterCore uut (
    .clk(clk), .rst(rst), .start(start), .plainText(plainText),
    .cipherKey(cipherKey), .busy(busy), .done(done), .cipherText(cipherText)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] prod = '0;
    for (int i = 0; i < 8; i++) if (b[i]) prod ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (prod[i]) prod ^= 16'h11b << (i - 8);
    return prod[7:0];
  endfunction

  task automatic buildTable();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      for (int y = 1; y < 256; y++) if (refMul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ 8'h63 >> i & 1'b1;
      sbTbl[x] = s;
    end
  endtask

  function automatic logic [127:0] refEncrypt(input logic [127:0] pt, input logic [127:0] key);
    logic [7:0] st [16];
    logic [7:0] tp [16];
    logic [7:0] rk [16];
    logic [7:0] rc = 8'h01;
    logic [7:0] t0, t1, t2, t3;
    logic [127:0] res;
    for (int k = 0; k < 16; k++) begin
      rk[k] = key[127-8*k -: 8];
      st[k] = pt[127-8*k -: 8] ^ rk[k];
    end
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int k = 0; k < 16; k++) st[k] = sbTbl[st[k]];
      for (int k = 0; k < 16; k++) tp[k] = st[(k % 4) + 4 * (((k / 4) + (k % 4)) % 4)];
      for (int c = 0; c < 4; c++) begin
        if (rnd < 10) begin
          st[4*c]   = refMul(tp[4*c],8'h02) ^ refMul(tp[4*c+1],8'h03) ^ tp[4*c+2] ^ tp[4*c+3];
          st[4*c+1] = tp[4*c] ^ refMul(tp[4*c+1],8'h02) ^ refMul(tp[4*c+2],8'h03) ^ tp[4*c+3];
          st[4*c+2] = tp[4*c] ^ tp[4*c+1] ^ refMul(tp[4*c+2],8'h02) ^ refMul(tp[4*c+3],8'h03);
          st[4*c+3] = refMul(tp[4*c],8'h03) ^ tp[4*c+1] ^ tp[4*c+2] ^ refMul(tp[4*c+3],8'h02);
        end else begin
          for (int r = 0; r < 4; r++) st[4*c+r] = tp[4*c+r];
        end
      end
      t0 = sbTbl[rk[13]]; t1 = sbTbl[rk[14]]; t2 = sbTbl[rk[15]]; t3 = sbTbl[rk[12]];
      rk[0] ^= t0 ^ rc; rk[1] ^= t1; rk[2] ^= t2; rk[3] ^= t3;
      for (int k = 4; k < 16; k++) rk[k] ^= rk[k-4];
      rc = refMul(rc, 8'h02);
      for (int k = 0; k < 16; k++) st[k] ^= rk[k];
    end
    for (int k = 0; k < 16; k++) res[127-8*k -: 8] = st[k];
    return res;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // start at a negedge, count edges until done is seen; result sampled at negedge
  task automatic runBlock(input logic [127:0] pt, input logic [127:0] key,
                          output logic [127:0] ct, output int lat);
    plainText = pt; cipherKey = key; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    ct = cipherText;
  endtask

  task automatic testReset();  // R1
    check("R1 busy", 128'(busy), 128'(0));
    check("R1 done", 128'(done), 128'(0));
    check("R1 cipherText", cipherText, 128'(0));
  endtask

  task automatic testStandard();  // R6 R8
    logic [127:0] ct;
    int lat;
    logic [127:0] k = 128'h000102030405060708090a0b0c0d0e0f;
    logic [127:0] p = 128'h00112233445566778899aabbccddeeff;
    logic [127:0] e = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    check("R6 model", refEncrypt(p, k), e);
    runBlock(p, k, ct, lat);
    check("R6 R8 cipherText", ct, e);
    check("R3 latency", 128'(lat), 128'(11));
    @(negedge clk);
    check("R4 done low", 128'(done), 128'(0));
    repeat (3) @(negedge clk);
    check("R7 held", cipherText, e);
  endtask

  task automatic testRandom();  // R9
    for (int n = 0; n < 5; n++) begin
      logic [127:0] p = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] k = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] ct;
      int lat;
      runBlock(p, k, ct, lat);
      check("R9 random", ct, refEncrypt(p, k));
      check("R3 latency", 128'(lat), 128'(11));
      @(negedge clk);
    end
  endtask

  task automatic testIgnore();  // R5 R2
    logic [127:0] pA = 128'h0123456789abcdeffedcba9876543210;
    logic [127:0] kA = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    int lat;
    plainText = pA; cipherKey = kA; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy", 128'(busy), 128'(1));
    lat = 1;
    repeat (3) begin @(negedge clk); lat++; end
    plainText = ~pA; cipherKey = ~kA; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    check("R5 result", cipherText, refEncrypt(pA, kA));
    check("R5 latency", 128'(lat), 128'(11));
    @(negedge clk);
    check("R5 no second run", 128'(busy), 128'(0));
  endtask

  task automatic testBackToBack();  // R10
    logic [127:0] p1 = 128'h3243f6a8885a308d313198a2e0370734;
    logic [127:0] k1 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    logic [127:0] p2 = 128'hffeeddccbbaa99887766554433221100;
    logic [127:0] k2 = 128'h0f0e0d0c0b0a09080706050403020100;
    logic [127:0] ct;
    int lat;
    runBlock(p1, k1, ct, lat);
    check("R10 first", ct, refEncrypt(p1, k1));
    runBlock(p2, k2, ct, lat);  // start raised while done is high
    check("R10 second", ct, refEncrypt(p2, k2));
    check("R10 latency", 128'(lat), 128'(11));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    buildTable();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testStandard();
    testRandom();
    testIgnore();
    testBackToBack();
    finishRun();
  end
endmodule